// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a single-ported synchronous burst SRAM with flow-through reads. Each word has a configurable number of byte lanes. In the default lane layout a lane is 9 bits wide: 8 data bits and 1 parity bit. The full-size instance sets `ADDR_W` to 18, which gives 262,144 words of 18 bits. The default keeps the array small so that the block elaborates quickly.

Reads and writes can follow one another on every enabled clock edge with no idle cycles. Write data trails its address by one enabled edge, so a write that directly follows a read never has to wait for the data bus to turn around. A load cycle starts an access. Each following continue cycle advances through a burst of 2^`BURST_W` beats. The burst keeps the direction chosen at its load cycle, and its low address bits follow a linear or an interleaved order, set by a parameter.

When the active-low clock enable is high, the whole pipeline freezes, including any write data that is still owed. A sleep input also freezes the pipeline, and it forces the output-valid flag low. That flag stands in for a tristate data bus.

Top module: `zt_sram`

## Requirements
- R1: The array holds 2^`ADDR_W` words of `LANES`×`LANE_W` bits. A read of any address returns the last data written to each lane of that word.
- R2: While `clk_en_n` is high, clock edges are ignored. `rdata` and `rdata_oe` hold their values. A write whose data is still owed stays pending, and it takes `wdata` at the next edge where `clk_en_n` is low.
- R3: Lane i is bits [i*`LANE_W` +: `LANE_W`] and is written only when `lane_wr_n[i]` is 0 in the address cycle. Any mix of strobes is valid, and with all strobes at 1 a write changes nothing.
- R4: Write data for an address is sampled from `wdata` on the first enabled edge after the edge that sampled the address.
- R5: A read sampled at an enabled edge puts its word on `rdata` during the following cycle, with `rdata_oe` at 1 (when `out_en_n` is 0 and `sleep` is 0).
- R6: A read issued at the edge right after a write to the same address returns the new data in the strobed lanes and the old contents in the other lanes.
- R7: A load cycle (`adv_ld_n` = 0) with `chip_sel_n` = 1 deselects the block. `rdata_oe` is 0 in the next cycle and the array is not touched. Continue cycles after a deselect also access nothing.
- R8: On a continue cycle (`adv_ld_n` = 1) the burst keeps the direction of its load cycle, and `chip_sel_n` and `wr_n` are ignored. The upper address bits stay fixed. For beat k, the low `BURST_W` bits are (base+k) mod 2^`BURST_W` when `LINEAR` = 1, and base XOR k when `LINEAR` = 0. Burst writes use the strobes sampled in each beat's own cycle.
- R9: While `sleep` is 1, all synchronous inputs are ignored as in R2, and `rdata_oe` is 0.
- R10: `out_en_n` = 1 forces `rdata_oe` to 0 at once, without a clock edge. It does not alter the pipeline.
- R11: After `rst_n` is asserted, no read or write is pending and `rdata_oe` is 0. The array contents are not cleared.
- R12: In the cycle after a write address is sampled, `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state |
| clk_en_n | input | 1 | Active-low clock qualifier; high stalls the block |
| chip_sel_n | input | 1 | Active-low select, sampled on load cycles |
| adv_ld_n | input | 1 | 0 = load new address and command, 1 = continue burst |
| wr_n | input | 1 | 0 = write, 1 = read, sampled on load cycles |
| lane_wr_n | input | LANES | Active-low per-lane write strobes |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, one enabled edge after its address |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Sleep: inputs ignored, outputs idle |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rdata_oe | output | 1 | High when rdata would be driven onto the bus |

## Verification
The bench builds two copies of the block with `ADDR_W` = 4, so that the whole 16-word array can be filled and swept. The default `BURST_W` of 2 and the two-lane, 9-bit lane layout stay as they are. One copy uses the linear burst order and the other uses the interleaved order. Both receive the same command stream, so every base offset within a 4-beat burst, every strobe mix and every wrap point is covered in both modes. Each output is compared with an arithmetic model of addresses and lane merges.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/zt_sram_burst_ctr.sv
module zt_sram_burst_ctr #(
   parameter int BURST_W = 2,
   parameter bit LINEAR  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   input  logic               load,
   input  logic               adv,
   input  logic [BURST_W-1:0] base_lo,
   output logic [BURST_W-1:0] acc_lo
);
   logic [BURST_W-1:0] base_q;
   logic [BURST_W-1:0] cnt_q;
   logic [BURST_W-1:0] beat;
   logic [BURST_W-1:0] base_sel;

   assign beat     = load ? '0 : cnt_q + 1'b1;
   assign base_sel = load ? base_lo : base_q;

   generate
      if (LINEAR) begin : g_linear
         assign acc_lo = base_sel + beat;
      end else begin : g_interleave
         assign acc_lo = base_sel ^ beat;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (step) begin
         if (load) begin
            base_q <= base_lo;
            cnt_q  <= '0;
         end else if (adv) begin
            cnt_q <= beat;
         end
      end
   end

   // R8
   burst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && load) |=> (cnt_q == '0));

   // R8
   burst_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && adv) |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int LANES   = 2,
   parameter int BURST_W = 2,
   parameter bit LINEAR  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              adv_ld_n,
   input  logic              chip_sel_n,
   input  logic              wr_n,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [LANES-1:0]  wr_lanes,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr
);
   localparam int UP_W = ADDR_W - BURST_W;

   logic              load;
   logic              active_q;
   logic              is_wr_q;
   logic [UP_W-1:0]   up_q;
   logic [BURST_W-1:0] acc_lo;
   logic [ADDR_W-1:0] acc_addr;
   op_e               cur_op;
   logic              pend_valid_q;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [LANES-1:0]  pend_lanes_q;
   logic              rd_valid_q;
   logic [ADDR_W-1:0] rd_addr_q;

   assign load = !adv_ld_n;

   zt_sram_burst_ctr #(
      .BURST_W (BURST_W),
      .LINEAR  (LINEAR)
   ) burst_ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .load    (load),
      .adv     (active_q),
      .base_lo (addr[BURST_W-1:0]),
      .acc_lo  (acc_lo)
   );

   always_comb begin
      if (load) begin
         if (chip_sel_n)  cur_op = OP_IDLE;
         else if (wr_n)   cur_op = OP_READ;
         else             cur_op = OP_WRITE;
      end else if (active_q) begin
         cur_op = is_wr_q ? OP_WRITE : OP_READ;
      end else begin
         cur_op = OP_IDLE;
      end
   end

   assign acc_addr = {(load ? addr[ADDR_W-1:BURST_W] : up_q), acc_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q     <= 1'b0;
         is_wr_q      <= 1'b0;
         up_q         <= '0;
         pend_valid_q <= 1'b0;
         pend_addr_q  <= '0;
         pend_lanes_q <= '0;
         rd_valid_q   <= 1'b0;
         rd_addr_q    <= '0;
      end else if (step) begin
         if (load) begin
            active_q <= !chip_sel_n;
            is_wr_q  <= !wr_n;
            up_q     <= addr[ADDR_W-1:BURST_W];
         end
         pend_valid_q <= (cur_op == OP_WRITE);
         pend_addr_q  <= acc_addr;
         pend_lanes_q <= ~lane_wr_n;
         rd_valid_q   <= (cur_op == OP_READ);
         rd_addr_q    <= acc_addr;
      end
   end

   assign wr_en    = step && pend_valid_q;
   assign wr_lanes = pend_lanes_q;
   assign wr_addr  = pend_addr_q;
   assign rd_valid = rd_valid_q;
   assign rd_addr  = rd_addr_q;

   // R2
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(rd_valid_q) && $stable(rd_addr_q) &&
                 $stable(pend_valid_q) && $stable(pend_addr_q)));

   // R7
   deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && load && chip_sel_n) |=> (!rd_valid_q && !pend_valid_q));

   // R8
   burst_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && active_q && is_wr_q) |=> (pend_valid_q && !rd_valid_q));
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
   parameter int ADDR_W = 10,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [LANES-1:0]        we_lanes,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (we && we_lanes[g]) begin
               mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
         end

         assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
   parameter int ADDR_W  = 10,
   parameter int LANE_W  = 9,
   parameter int LANES   = 2,
   parameter int BURST_W = 2,
   parameter bit LINEAR  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    chip_sel_n,
   input  logic                    adv_ld_n,
   input  logic                    wr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    out_en_n,
   input  logic                    sleep,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);
   localparam int WORD_W = LANES * LANE_W;

   generate
      if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
         $error("zt_sram: BURST_W must lie in 1 .. ADDR_W-1");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("zt_sram: LANES and LANE_W must be positive");
      end
   endgenerate

   logic              step;
   logic              wr_en;
   logic [LANES-1:0]  wr_lanes;
   logic [ADDR_W-1:0] wr_addr;
   logic              rd_valid;
   logic [ADDR_W-1:0] rd_addr;
   logic [WORD_W-1:0] arr_rdata;

   assign step = !clk_en_n && !sleep;

   zt_sram_ctrl #(
      .ADDR_W  (ADDR_W),
      .LANES   (LANES),
      .BURST_W (BURST_W),
      .LINEAR  (LINEAR)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .adv_ld_n   (adv_ld_n),
      .chip_sel_n (chip_sel_n),
      .wr_n       (wr_n),
      .lane_wr_n  (lane_wr_n),
      .addr       (addr),
      .wr_en      (wr_en),
      .wr_lanes   (wr_lanes),
      .wr_addr    (wr_addr),
      .rd_valid   (rd_valid),
      .rd_addr    (rd_addr)
   );

   zt_sram_array #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) array_i (
      .clk      (clk),
      .we       (wr_en),
      .we_lanes (wr_lanes),
      .waddr    (wr_addr),
      .wdata    (wdata),
      .raddr    (rd_addr),
      .rdata    (arr_rdata)
   );

   assign rdata    = arr_rdata;
   assign rdata_oe = rd_valid && !out_en_n && !sleep;

   // R12
   write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !adv_ld_n && !chip_sel_n && !wr_n) |=> !rd_valid);
endmodule

// File: tb/zt_sram_tb_top.sv
module zt_sram_tb_top;
   localparam int AW = 4;
   localparam int LW = 9;
   localparam int NL = 2;
   localparam int WW = NL * LW;
   localparam int D  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_n = 1'b1;
   logic          chip_sel_n = 1'b1;
   logic          adv_ld_n = 1'b0;
   logic          wr_n = 1'b1;
   logic [NL-1:0] lane_wr_n = '1;
   logic [AW-1:0] addr = '0;
   logic [WW-1:0] wdata = '0;
   logic          out_en_n = 1'b0;
   logic          sleep = 1'b0;
   logic [WW-1:0] rd_lin, rd_ilv;
   logic          oe_lin, oe_ilv;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   zt_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL), .BURST_W(2), .LINEAR(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .chip_sel_n(chip_sel_n),
      .adv_ld_n(adv_ld_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
      .wdata(wdata), .out_en_n(out_en_n), .sleep(sleep), .rdata(rd_lin), .rdata_oe(oe_lin));

   zt_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL), .BURST_W(2), .LINEAR(1'b0)) dut_x (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .chip_sel_n(chip_sel_n),
      .adv_ld_n(adv_ld_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
      .wdata(wdata), .out_en_n(out_en_n), .sleep(sleep), .rdata(rd_ilv), .rdata_oe(oe_ilv));

   // reference model, index 0 = linear, 1 = interleaved
   logic [WW-1:0] mdl [2][D];
   bit       m_act [2];
   bit       m_wr  [2];
   int       m_base[2];
   int       m_k   [2];
   bit       m_pv  [2];
   int       m_pa  [2];
   bit [1:0] m_pl  [2];
   bit       m_rv  [2];
   int       m_ra  [2];

   function automatic int seq_addr(int base, int k, bit lin);
      int lo = base & 3;
      int hi = base & ~3;
      return hi | (lin ? ((lo + k) & 3) : (lo ^ (k & 3)));
   endfunction

   function automatic logic [WW-1:0] pat(int a, int salt);
      return WW'((a * 4093 + salt * 771 + 5) ^ (a << 9) ^ (salt << 13));
   endfunction

   task automatic chk(bit ok, string tag, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_outs(string tag);
      for (int m = 0; m < 2; m++) begin
         bit            exp_oe = m_rv[m] && !out_en_n && !sleep;
         logic          a_oe   = (m == 0) ? oe_lin : oe_ilv;
         logic [WW-1:0] a_rd   = (m == 0) ? rd_lin : rd_ilv;
         chk(a_oe == exp_oe, tag, (m == 0) ? "oe(lin)" : "oe(ilv)", WW'(a_oe), WW'(exp_oe));
         if (exp_oe)
            chk(a_rd == mdl[m][m_ra[m]], tag, (m == 0) ? "rdata(lin)" : "rdata(ilv)",
                a_rd, mdl[m][m_ra[m]]);
      end
   endtask

   // called at a falling edge: apply inputs, model the rising edge, check at next fall
   task automatic drive(bit en_n, bit cs_n, bit adv_n, bit we_n, bit [1:0] ln,
                        int a, logic [WW-1:0] d, bit oen, bit slp, string tag);
      clk_en_n = en_n; chip_sel_n = cs_n; adv_ld_n = adv_n; wr_n = we_n;
      lane_wr_n = ln; addr = AW'(a); wdata = d; out_en_n = oen; sleep = slp;
      @(posedge clk);
      if (!en_n && !slp) begin
         for (int m = 0; m < 2; m++) begin
            int op;
            int ea;
            if (m_pv[m])
               for (int l = 0; l < NL; l++)
                  if (m_pl[m][l]) mdl[m][m_pa[m]][l*LW +: LW] = d[l*LW +: LW];
            if (!adv_n) begin
               if (cs_n) begin
                  m_act[m] = 1'b0; op = 0;
               end else begin
                  m_act[m] = 1'b1; m_wr[m] = !we_n; m_base[m] = a & (D - 1); m_k[m] = 0;
                  op = we_n ? 1 : 2;
               end
            end else if (m_act[m]) begin
               m_k[m]++; op = m_wr[m] ? 2 : 1;
            end else begin
               op = 0;
            end
            ea = seq_addr(m_base[m], m_k[m], m == 0);
            m_pv[m] = (op == 2); m_pa[m] = ea; m_pl[m] = ~ln;
            m_rv[m] = (op == 1); m_ra[m] = ea;
         end
      end
      @(negedge clk);
      check_outs(tag);
   endtask

   task automatic op_wr(int a, bit [1:0] ln, logic [WW-1:0] d, string t);
      drive(1'b0, 1'b0, 1'b0, 1'b0, ln, a, d, 1'b0, 1'b0, t);
   endtask
   task automatic op_rd(int a, logic [WW-1:0] d, string t);
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, a, d, 1'b0, 1'b0, t);
   endtask
   task automatic op_cont(logic [WW-1:0] d, string t);
      drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 0, d, 1'b0, 1'b0, t);
   endtask
   task automatic op_desel(logic [WW-1:0] d, string t);
      drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 0, d, 1'b0, 1'b0, t);
   endtask
   task automatic op_stall(logic [WW-1:0] d, string t);
      drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 5, d, 1'b0, 1'b0, t);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      for (int m = 0; m < 2; m++) begin
         m_act[m] = 0; m_wr[m] = 0; m_base[m] = 0; m_k[m] = 0;
         m_pv[m] = 0; m_pa[m] = 0; m_pl[m] = 0; m_rv[m] = 0; m_ra[m] = 0;
      end
      repeat (3) @(negedge clk);
      // R11: reset state
      check_outs("R11");
      rst_n = 1'b1;
      @(negedge clk);
      check_outs("R11");

      // R12: back-to-back writes fill the array, bus stays idle
      for (int a = 0; a < D; a++) op_wr(a, 2'b00, pat(a - 1, 1), "R12");
      op_desel(pat(D - 1, 1), "R7");

      // R1 / R5: back-to-back read sweep
      for (int a = 0; a < D; a++) op_rd(a, '0, "R1/R5");

      // R3 write with each strobe mix, R6 read the same word on the next edge
      for (int a = 0; a < D; a++) begin
         op_wr(a, 2'(a), '0, "R3");
         op_rd(a, pat(a, 2), "R6");
      end

      // R4: data for address 12 is taken one enabled edge later
      op_wr(12, 2'b00, pat(0, 5), "R4");
      op_rd(13, pat(12, 7), "R4");
      op_rd(12, pat(1, 5), "R4");

      // R2: stall holds pending write data and read output
      op_wr(7, 2'b00, '0, "R2");
      for (int i = 0; i < 3; i++) op_stall(pat(i, 11), "R2");
      op_rd(7, pat(7, 9), "R2");
      op_stall(pat(3, 11), "R2");
      op_stall(pat(4, 11), "R2");
      op_rd(6, '0, "R2");

      // R8: read bursts from every base offset, cs/wr ignored on continue
      for (int b = 0; b < D; b += 3) begin
         op_rd(b, '0, "R8");
         for (int k = 0; k < 5; k++) op_cont('0, "R8");
      end
      // R8: write burst with per-beat data, then read back
      op_wr(9, 2'b00, '0, "R8");
      for (int k = 0; k < 5; k++) op_cont(pat(k, 21), "R8");
      op_rd(8, pat(5, 21), "R8");
      for (int a = 9; a < 12; a++) op_rd(a, '0, "R8");

      // R7: deselect, continues after it access nothing
      op_desel('0, "R7");
      op_cont(pat(1, 31), "R7");
      op_cont(pat(2, 31), "R7");
      for (int a = 0; a < D; a++) op_rd(a, '0, "R7");

      // R9: sleep ignores a write and blanks the bus
      op_rd(2, '0, "R9");
      drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4, pat(4, 41), 1'b0, 1'b1, "R9");
      drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4, pat(4, 42), 1'b0, 1'b1, "R9");
      op_rd(4, pat(4, 43), "R9");
      op_rd(5, '0, "R9");

      // R10: output enable masks the flag without disturbing the pipeline
      op_rd(3, '0, "R10");
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 6, '0, 1'b1, 1'b0, "R10");
      out_en_n = 1'b0;
      #1;
      check_outs("R10");
      out_en_n = 1'b1;
      #1;
      check_outs("R10");
      out_en_n = 1'b0;
      #1;
      check_outs("R10");
      @(negedge clk);
      op_rd(1, '0, "R10");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule